// File: doc/BRIEF.md
# Tagged Memory Write Controller

This block fronts a small data memory. The memory is split into double-width regions: one region holds one capability of CLEN = 2*XLEN bits. Each region carries one hidden validity tag. No address reaches the tag. A capability store is the only way to set it, and a capability load is the only way to read it.

The data lanes and the tag of a region are written in the same clock edge. A load can therefore never return new data with an old tag, or old data with a new tag. The tag ends up set only when a full-width capability store carries a set tag bit. Every other kind of write leaves the tag clear: byte, halfword and word integer stores, and capability stores whose tag bit is zero. A requester issues at most one operation per cycle. A capability load answers one cycle later with the whole region and its tag. An access that breaks the natural alignment of its size is refused. The refusal appears as a one-cycle error pulse, and the memory does not change.

Top module: `tagged_mem_ctrl`

## Requirements
- R1: After synchronous reset every region's tag and data read back as zero, and `rsp_valid` and `err_valid` are low.
- R2: An aligned capability store (op 4) with `req_tag`=1 writes all CLEN bits of the region addressed by `req_addr[AW-1:OFFW]` (OFFW = log2(CLEN/8)) and sets its tag.
- R3: An aligned capability store with `req_tag`=0 writes all CLEN bits and clears the region's tag.
- R4: Integer stores of 1, 2 or XLEN/8 bytes write only their byte lanes and clear the tag of the containing region. The ops are 1, 2 and 3 respectively. Byte k of a region occupies bits 8k+7:8k, the store data is taken from the low bits of `req_wdata`, and the other bytes keep their value.
- R5: An aligned capability load (op 5) raises `rsp_valid` for exactly the next cycle, with the region's full data on `rsp_data` and its tag on `rsp_tag`.
- R6: A capability store or load whose address is not CLEN/8-byte aligned raises `err_valid` for the next cycle only. It gives no `rsp_valid` and changes no data or tag.
- R7: A halfword or word store that is not naturally aligned is refused in the same way: `err_valid` pulses for one cycle and nothing changes.
- R8: A store changes neither the data nor the tag of any region other than the one it addresses.
- R9: With `req_valid` low, or with an unused op code (0, 6, 7), the block produces no output and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 1 byte, 2 half, 3 word store; 4 capability store; 5 capability load |
| req_addr | input | AW | Byte address |
| req_wdata | input | CLEN | Store data, low-aligned for integer stores |
| req_tag | input | 1 | Tag of the capability being stored |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | CLEN | Loaded region data |
| rsp_tag | output | 1 | Loaded region tag |
| err_valid | output | 1 | Alignment refusal pulse |

## Verification
Tag state is hidden, so a corrupted tag shows only through a later capability load. Each store test is followed by a load of the same region and of a neighbouring region. A wrong write rule then shows as a wrong `rsp_tag` or wrong `rsp_data` two cycles after the faulty store. Refused accesses are followed by loads, so that a partial write caused by a missed alignment check becomes visible. Every cycle is also checked for response or error pulses that no request explains.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_ST_B   = 3'd1,
        OP_ST_H   = 3'd2,
        OP_ST_W   = 3'd3,
        OP_ST_CAP = 3'd4,
        OP_LD_CAP = 3'd5
    } tmw_op_e;

    function automatic logic op_is_store(input tmw_op_e op);
        return (op == OP_ST_B) || (op == OP_ST_H) || (op == OP_ST_W) || (op == OP_ST_CAP);
    endfunction

    function automatic logic op_is_load(input tmw_op_e op);
        return op == OP_LD_CAP;
    endfunction

    // access size in bytes; zero for ops that touch nothing
    function automatic int unsigned op_size(input tmw_op_e op, input int unsigned word_bytes,
                                            input int unsigned cap_bytes);
        case (op)
            OP_ST_B:              return 1;
            OP_ST_H:              return 2;
            OP_ST_W:              return word_bytes;
            OP_ST_CAP, OP_LD_CAP: return cap_bytes;
            default:              return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmw_decode.sv
module tmw_decode
    import tmw_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    localparam int CLEN = 2 * XLEN,
    localparam int CB   = CLEN / 8,
    localparam int OFFW = $clog2(CB),
    localparam int IW   = $clog2(DEPTH),
    localparam int AW   = OFFW + IW
) (
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [CLEN-1:0] req_wdata,
    input  logic            req_tag,
    output logic            wr_en,
    output logic            rd_en,
    output logic            err,
    output logic [IW-1:0]   idx,
    output logic [CB-1:0]   byte_en,
    output logic [CLEN-1:0] wr_data,
    output logic            tag_val
);
    tmw_op_e     op;
    int unsigned nbytes;
    int unsigned off;
    logic        misaligned;
    logic        known;

    always_comb begin
        op         = tmw_op_e'(req_op);
        nbytes     = op_size(op, XLEN / 8, CB);
        off        = int'(req_addr[OFFW-1:0]);
        known      = op_is_store(op) || op_is_load(op);
        misaligned = (nbytes != 0) && ((off % nbytes) != 0);
        err        = req_valid && known && misaligned;
        wr_en      = req_valid && op_is_store(op) && !misaligned;
        rd_en      = req_valid && op_is_load(op) && !misaligned;
        idx        = req_addr[AW-1:OFFW];
        wr_data    = req_wdata << (8 * off);
        tag_val    = (op == OP_ST_CAP) && req_tag;
        for (int k = 0; k < CB; k++) begin
            byte_en[k] = (k >= off) && (k < off + nbytes);
        end
    end

endmodule

// File: rtl/tmw_store.sv
module tmw_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    localparam int CLEN = 2 * XLEN,
    localparam int CB   = CLEN / 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   idx,
    input  logic [CB-1:0]   byte_en,
    input  logic [CLEN-1:0] wr_data,
    input  logic            tag_val,
    output logic [CLEN-1:0] rd_data,
    output logic            rd_tag
);
    logic [CLEN-1:0] data_q [DEPTH];
    logic            tag_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_region
        // data lanes and tag share one enable: both change on the same edge
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
                tag_q[g]  <= 1'b0;
            end else if (wr_en && idx == IW'(g)) begin
                for (int k = 0; k < CB; k++) begin
                    if (byte_en[k]) data_q[g][8*k +: 8] <= wr_data[8*k +: 8];
                end
                tag_q[g] <= tag_val;
            end
        end
    end

    assign rd_data = data_q[idx];
    assign rd_tag  = tag_q[idx];

endmodule

// File: rtl/tmw_resp.sv
module tmw_resp #(
    parameter int XLEN = 32,
    localparam int CLEN = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic            err,
    input  logic [CLEN-1:0] rd_data,
    input  logic            rd_tag,
    output logic            rsp_valid,
    output logic [CLEN-1:0] rsp_data,
    output logic            rsp_tag,
    output logic            err_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tag   <= 1'b0;
            err_valid <= 1'b0;
        end else begin
            rsp_valid <= rd_en;
            err_valid <= err;
            if (rd_en) begin
                rsp_data <= rd_data;
                rsp_tag  <= rd_tag;
            end
        end
    end

endmodule

// File: rtl/tagged_mem_ctrl.sv
module tagged_mem_ctrl #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    localparam int CLEN = 2 * XLEN,
    localparam int CB   = CLEN / 8,
    localparam int OFFW = $clog2(CB),
    localparam int IW   = $clog2(DEPTH),
    localparam int AW   = OFFW + IW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [CLEN-1:0] req_wdata,
    input  logic            req_tag,
    output logic            rsp_valid,
    output logic [CLEN-1:0] rsp_data,
    output logic            rsp_tag,
    output logic            err_valid
);
    logic            wr_en, rd_en, err, tag_val, rd_tag;
    logic [IW-1:0]   idx;
    logic [CB-1:0]   byte_en;
    logic [CLEN-1:0] wr_data, rd_data;

    tmw_decode #(.XLEN(XLEN), .DEPTH(DEPTH)) u_decode (
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_tag(req_tag),
        .wr_en(wr_en), .rd_en(rd_en), .err(err), .idx(idx),
        .byte_en(byte_en), .wr_data(wr_data), .tag_val(tag_val)
    );

    tmw_store #(.XLEN(XLEN), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .byte_en(byte_en),
        .wr_data(wr_data), .tag_val(tag_val), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    tmw_resp #(.XLEN(XLEN)) u_resp (
        .clk(clk), .rst(rst), .rd_en(rd_en), .err(err), .rd_data(rd_data),
        .rd_tag(rd_tag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .err_valid(err_valid)
    );

endmodule

// File: rtl/tmw_checker.sv
module tmw_checker #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    localparam int CLEN = 2 * XLEN,
    localparam int CB   = CLEN / 8,
    localparam int OFFW = $clog2(CB),
    localparam int IW   = $clog2(DEPTH),
    localparam int AW   = OFFW + IW
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [AW-1:0]   req_addr,
    input logic [CLEN-1:0] req_wdata,
    input logic            req_tag,
    input logic            rsp_valid,
    input logic [CLEN-1:0] rsp_data,
    input logic            rsp_tag,
    input logic            err_valid
);
    logic cap_op, cap_odd;
    assign cap_op  = req_valid && (req_op == 3'd4 || req_op == 3'd5);
    assign cap_odd = req_addr[OFFW-1:0] != '0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !err_valid));

    assert_load_answers_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5 && !cap_odd) |=> rsp_valid);

    assert_rsp_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_op == 3'd5));

    assert_cap_misalign_err_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_op && cap_odd) |=> (err_valid && !rsp_valid));

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !err_valid));

    assert_tagged_roundtrip_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5 && !cap_odd && $past(req_valid) &&
         $past(req_op) == 3'd4 && $past(req_tag) && $past(req_addr) == req_addr)
        |=> (rsp_tag && rsp_data == $past(req_wdata, 2)));

    assert_int_store_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5 && !cap_odd && $past(req_valid) &&
         $past(req_op) == 3'd1 && $past(req_addr[AW-1:OFFW]) == req_addr[AW-1:OFFW])
        |=> !rsp_tag);

endmodule

bind tagged_mem_ctrl tmw_checker #(.XLEN(XLEN), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tagged_mem_ctrl_bench.sv
module tagged_mem_ctrl_bench;
    localparam int XLEN  = 32;
    localparam int DEPTH = 16;
    localparam int CLEN  = 2 * XLEN;
    localparam int CB    = CLEN / 8;
    localparam int AW    = $clog2(CB) + $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = 3'd0;
    logic [AW-1:0]   req_addr = '0;
    logic [CLEN-1:0] req_wdata = '0;
    logic            req_tag = 1'b0;
    logic            rsp_valid, rsp_tag, err_valid;
    logic [CLEN-1:0] rsp_data;

    always #5 clk = ~clk;

    tagged_mem_ctrl #(.XLEN(XLEN), .DEPTH(DEPTH)) u_tagged_mem_ctrl (.*);

    typedef struct {
        logic            is_err;
        logic [CLEN-1:0] data;
        logic            tag;
        int              due;
        string           rq;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  mem_m [DEPTH*CB];
    logic        tag_m [DEPTH];
    int          cyc = 0;
    int          tests = 0;
    int          fails = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [CLEN-1:0] region(input int r);
        logic [CLEN-1:0] v;
        for (int k = 0; k < CB; k++) v[8*k +: 8] = mem_m[r*CB + k];
        return v;
    endfunction

    // driver: computes the expected outcome from the requirements and queues it
    task automatic issue(input logic [2:0] op, input int addr, input logic [CLEN-1:0] d,
                         input logic tg, input string rq, input logic vld = 1'b1);
        int   nb;
        int   off;
        int   r;
        exp_t e;
        @(posedge clk);
        #2;
        req_valid = vld; req_op = op; req_addr = AW'(addr); req_wdata = d; req_tag = tg;
        nb  = (op == 3'd1) ? 1 : (op == 3'd2) ? 2 : (op == 3'd3) ? XLEN/8 :
              (op == 3'd4 || op == 3'd5) ? CB : 0;
        off = addr % CB;
        r   = addr / CB;
        if (!vld || nb == 0) return;
        e.due = cyc + 1; e.rq = rq; e.data = '0; e.tag = 1'b0; e.is_err = 1'b0;
        if (off % nb != 0) begin
            e.is_err = 1'b1;
            sb.push_back(e);
        end else if (op == 3'd5) begin
            e.data = region(r); e.tag = tag_m[r];
            sb.push_back(e);
        end else begin
            for (int k = 0; k < nb; k++) mem_m[r*CB + off + k] = d[8*k +: 8];
            tag_m[r] = (op == 3'd4) && tg;
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    // monitor: pops and compares when an item falls due; flags unexplained pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() != 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                tests++;
                if (e.is_err) begin
                    if (!err_valid || rsp_valid) begin
                        fails++;
                        $display("FAIL %s: err=%0b rsp=%0b, expected err=1 rsp=0",
                                 e.rq, err_valid, rsp_valid);
                    end
                end else if (!rsp_valid || err_valid || rsp_data !== e.data || rsp_tag !== e.tag) begin
                    fails++;
                    $display("FAIL %s: rsp=%0b err=%0b data=%h tag=%0b, expected rsp=1 err=0 data=%h tag=%0b",
                             e.rq, rsp_valid, err_valid, rsp_data, rsp_tag, e.data, e.tag);
                end
            end else if (rsp_valid || err_valid) begin
                tests++; fails++;
                $display("FAIL R9: unexpected rsp=%0b err=%0b, expected none", rsp_valid, err_valid);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    localparam logic [CLEN-1:0] P1 = 64'hDEAD_BEEF_0123_4567;
    localparam logic [CLEN-1:0] P2 = 64'h0F1E_2D3C_4B5A_6978;
    localparam logic [CLEN-1:0] P3 = 64'hA5A5_5A5A_C3C3_3C3C;

    initial begin
        for (int i = 0; i < DEPTH*CB; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < DEPTH; i++) tag_m[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0 || err_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp=%0b err=%0b in reset, expected 0 0", rsp_valid, err_valid);
        end
        rst = 1'b0;

        // R1: cleared state after reset, first and last region
        issue(3'd5, 0, '0, 0, "R1");
        issue(3'd5, 15*8, '0, 0, "R1");

        // R2/R5: tagged capability store then back-to-back loads
        issue(3'd4, 3*8, P1, 1, "R2");
        issue(3'd5, 3*8, '0, 0, "R2");
        issue(3'd5, 3*8, '0, 0, "R5");
        issue(3'd4, 15*8, P3, 1, "R2");
        issue(3'd5, 15*8, '0, 0, "R2");

        // R3: untagged capability store over a tagged region
        issue(3'd4, 4*8, P2, 1, "R3");
        issue(3'd4, 4*8, P3, 0, "R3");
        issue(3'd5, 4*8, '0, 0, "R3");

        // R4: byte, half, word stores with junk in the unused upper bits
        issue(3'd4, 6*8, P1, 1, "R4");
        issue(3'd1, 6*8+5, 64'hFFFF_FFFF_FFFF_FF3C, 0, "R4");
        issue(3'd5, 6*8, '0, 0, "R4");
        issue(3'd4, 7*8, P2, 1, "R4");
        issue(3'd2, 7*8+6, 64'h1111_1111_1111_ABCD, 1, "R4");
        issue(3'd5, 7*8, '0, 0, "R4");
        issue(3'd4, 8*8, P3, 1, "R4");
        issue(3'd3, 8*8+4, 64'h7777_7777_89AB_CDEF, 1, "R4");
        issue(3'd5, 8*8, '0, 0, "R4");

        // R8: neighbours keep data and tag
        issue(3'd4, 9*8, P1, 1, "R8");
        issue(3'd4, 10*8, P2, 1, "R8");
        issue(3'd1, 9*8, 64'h5A, 0, "R8");
        issue(3'd5, 10*8, '0, 0, "R8");
        issue(3'd5, 9*8, '0, 0, "R8");
        issue(3'd5, 3*8, '0, 0, "R8");

        // R6: misaligned capability accesses refused, region unchanged
        issue(3'd4, 11*8, P2, 1, "R6");
        issue(3'd4, 11*8+4, P3, 0, "R6");
        issue(3'd5, 11*8, '0, 0, "R6");
        issue(3'd5, 11*8+2, '0, 0, "R6");
        issue(3'd5, 11*8, '0, 0, "R6");

        // R7: misaligned half and word stores refused
        issue(3'd4, 12*8, P1, 1, "R7");
        issue(3'd2, 12*8+1, 64'hBEEF, 0, "R7");
        issue(3'd3, 12*8+2, 64'hCAFE_F00D, 0, "R7");
        issue(3'd5, 12*8, '0, 0, "R7");
        issue(3'd1, 12*8+7, 64'h99, 0, "R7");
        issue(3'd5, 12*8, '0, 0, "R7");

        // R9: invalid requests and unused op codes change nothing
        issue(3'd4, 13*8, P3, 1, "R9");
        issue(3'd4, 13*8, P1, 0, "R9", 1'b0);
        issue(3'd1, 13*8, 64'h00, 0, "R9", 1'b0);
        issue(3'd6, 13*8, P2, 0, "R9");
        issue(3'd7, 13*8+1, P2, 0, "R9");
        issue(3'd0, 13*8, P2, 0, "R9");
        issue(3'd5, 13*8, '0, 0, "R9");

        idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d responses missing, expected 0", sb.size());
        end
        finish_run();
    end

endmodule